// File: doc/BRIEF.md
# Format-Aware Receive Sample Saturator

This block sits at the end of a receive data path whose samples carry a few bits of headroom beyond the 16-bit word that leaves the chip. Each sample that arrives with its valid strobe is clamped to the range of the output format selected in that cycle. The word is then registered and presented one clock later, together with a delayed valid.

Two output formats exist. With one sign bit, the full signed 16-bit range is used. With two sign bits, the range is halved, so the top two bits of every word are always equal. Whenever a valid sample has to be clamped, a clip indicator is raised. The indicator is sticky: it stays high until a clear request arrives from the control path. If a clear request and a new clipping sample occur in the same cycle, the new event wins and the indicator stays high.

Top module: `rx_sat_clip`

## Requirements
- R1: While rst_ni is low, word_o is 0x0000, word_vld_o is 0 and clip_o is 0.
- R2: word_vld_o equals smp_vld_i delayed by one clock. word_o changes only on the clock edge after a cycle with smp_vld_i high, and otherwise holds its value.
- R3: With fmt_one_sign_i = 1, a sample in the range -32768..32767 appears on word_o as its low 16 bits, unchanged.
- R4: With fmt_one_sign_i = 1, a sample above 32767 gives 0x7FFF and a sample below -32768 gives 0x8000.
- R5: With fmt_one_sign_i = 0, a sample in the range -16384..16383 appears on word_o as its low 16 bits, unchanged.
- R6: With fmt_one_sign_i = 0, a sample above 16383 gives 0x3FFF and a sample below -16384 gives 0xC000, so bits 15 and 14 of word_o are always equal.
- R7: clip_o goes high on the clock edge after a cycle in which smp_vld_i is high and the sample is clamped. An in-range sample, or out-of-range data with smp_vld_i low, does not raise it.
- R8: Once clip_o is high, it stays high until a cycle with clip_clr_i high. After such a cycle with no new clamping event, it is low on the next edge.
- R9: If a cycle has clip_clr_i high and also a valid sample that is clamped, clip_o is high after the edge.
- R10: The format is taken from fmt_one_sign_i in the same cycle as the sample, so the format may change from one sample to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 18 | Raw signed sample with headroom |
| smp_vld_i | input | 1 | Sample valid strobe |
| fmt_one_sign_i | input | 1 | 1: one sign bit and 15 data bits; 0: two sign bits and 14 data bits |
| clip_clr_i | input | 1 | Single-cycle request to clear the clip indicator |
| word_o | output | 16 | Clamped output word |
| word_vld_o | output | 1 | Output word valid |
| clip_o | output | 1 | Sticky clip indicator |

## Verification
The bench builds the block with its default widths: an 18-bit input and a 16-bit output. With these widths, samples two bits beyond the one-sign range and three bits beyond the two-sign range can be driven directly. The exact limits and the values one step past them are exercised in both formats, as are the extremes of the 18-bit input. A behavioural model runs alongside the design, and the format and the clear request are toggled from cycle to cycle. This lets the bench reach clears that coincide with clips, and out-of-range data on cycles that are not valid.

// File: rtl/satclip_pkg.sv
package satclip_pkg;
  typedef enum logic {
    FMT_TWO_SIGN = 1'b0,
    FMT_ONE_SIGN = 1'b1
  } fmt_e;
endpackage

// File: rtl/sat_range.sv
module sat_range #(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  smp_i,
  input  logic             one_sign_i,
  output logic             over_o,
  output logic             under_o,
  output logic [OUT_W-1:0] hi_o,
  output logic [OUT_W-1:0] lo_o
);
  localparam int EXT1 = IN_W - OUT_W + 1;
  localparam int EXT2 = IN_W - OUT_W + 2;
  localparam logic [IN_W-1:0] MAX1 = {{EXT1{1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic [IN_W-1:0] MIN1 = {{EXT1{1'b1}}, {(OUT_W-1){1'b0}}};
  localparam logic [IN_W-1:0] MAX2 = {{EXT2{1'b0}}, {(OUT_W-2){1'b1}}};
  localparam logic [IN_W-1:0] MIN2 = {{EXT2{1'b1}}, {(OUT_W-2){1'b0}}};

  logic [IN_W-1:0] hi_ext, lo_ext;

  always_comb begin
    hi_ext  = one_sign_i ? MAX1 : MAX2;
    lo_ext  = one_sign_i ? MIN1 : MIN2;
    over_o  = $signed(smp_i) > $signed(hi_ext);
    under_o = $signed(smp_i) < $signed(lo_ext);
    hi_o    = hi_ext[OUT_W-1:0];
    lo_o    = lo_ext[OUT_W-1:0];
  end

  always_comb begin
    // R4
    mutex_range_chk: assert (!(over_o && under_o));
  end
endmodule

// File: rtl/sat_stage.sv
module sat_stage #(
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OUT_W-1:0] low_i,
  input  logic             vld_i,
  input  logic             one_sign_i,
  input  logic             over_i,
  input  logic             under_i,
  input  logic [OUT_W-1:0] hi_i,
  input  logic [OUT_W-1:0] lo_i,
  output logic [OUT_W-1:0] word_o,
  output logic             vld_o
);
  logic [OUT_W-1:0] nxt;

  always_comb begin
    if (over_i)       nxt = hi_i;
    else if (under_i) nxt = lo_i;
    else              nxt = low_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) word_o <= nxt;
    end
  end

  // R2
  vld_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> (!vld_o && $stable(word_o)));
  // R6
  two_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !one_sign_i) |=> (word_o[OUT_W-1] == word_o[OUT_W-2]));
endmodule

// File: rtl/clip_sticky.sv
module clip_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // a new event beats a clear
    else if (clr_i) flag_o <= 1'b0;
  end

  // R8
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> flag_o);
endmodule

// File: rtl/rx_sat_clip.sv
module rx_sat_clip
  import satclip_pkg::*;
#(
  parameter int IN_W  = 18,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  smp_i,
  input  logic             smp_vld_i,
  input  logic             fmt_one_sign_i,
  input  logic             clip_clr_i,
  output logic [OUT_W-1:0] word_o,
  output logic             word_vld_o,
  output logic             clip_o
);
  fmt_e             fmt;
  logic             over, under;
  logic [OUT_W-1:0] hi, lo;

  assign fmt = fmt_e'(fmt_one_sign_i);

  sat_range #(.IN_W(IN_W), .OUT_W(OUT_W)) u_range (
    .smp_i     (smp_i),
    .one_sign_i(fmt == FMT_ONE_SIGN),
    .over_o    (over),
    .under_o   (under),
    .hi_o      (hi),
    .lo_o      (lo)
  );

  sat_stage #(.OUT_W(OUT_W)) u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .low_i     (smp_i[OUT_W-1:0]),
    .vld_i     (smp_vld_i),
    .one_sign_i(fmt == FMT_ONE_SIGN),
    .over_i    (over),
    .under_i   (under),
    .hi_i      (hi),
    .lo_i      (lo),
    .word_o    (word_o),
    .vld_o     (word_vld_o)
  );

  clip_sticky u_clip (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (smp_vld_i && (over || under)),
    .clr_i (clip_clr_i),
    .flag_o(clip_o)
  );

  // R7
  clip_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clip_o) |-> $past(smp_vld_i));
  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clip_clr_i && !smp_vld_i) |=> !clip_o);
endmodule

// File: tb/sim_rx_sat_clip.sv
module sim_rx_sat_clip;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [17:0] smp_i = '0;
  logic        smp_vld_i = 1'b0;
  logic        fmt_one_sign_i = 1'b0;
  logic        clip_clr_i = 1'b0;
  logic [15:0] word_o;
  logic        word_vld_o;
  logic        clip_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R1";

  logic [15:0] exp_word;
  logic        exp_vld;
  logic        exp_clip;

  always #10 clk_i = ~clk_i;

  rx_sat_clip u0 (.*);

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_word <= 16'h0000;
      exp_vld  <= 1'b0;
      exp_clip <= 1'b0;
    end else begin
      int v, mx, mn;
      bit sat;
      v   = int'($signed(smp_i));
      mx  = fmt_one_sign_i ? 32767 : 16383;
      mn  = fmt_one_sign_i ? -32768 : -16384;
      sat = (v > mx) || (v < mn);
      if (v > mx) v = mx;
      if (v < mn) v = mn;
      exp_vld <= smp_vld_i;
      if (smp_vld_i) exp_word <= v[15:0];
      if (smp_vld_i && sat) exp_clip <= 1'b1;
      else if (clip_clr_i)  exp_clip <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk_i) begin
    cycles++;
    chk(tag, word_o, exp_word, "word");
    chk(tag, {15'd0, word_vld_o}, {15'd0, exp_vld}, "valid");
    chk(tag, {15'd0, clip_o}, {15'd0, exp_clip}, "clip");
  end

  task automatic drive(input int v, input bit vld, input bit one, input bit clr, input string t);
    @(negedge clk_i);
    tag = t;
    smp_i = v[17:0];
    smp_vld_i = vld;
    fmt_one_sign_i = one;
    clip_clr_i = clr;
  endtask

  task automatic expect_now(input string req, input logic [15:0] w, input bit c);
    @(negedge clk_i);
    #1;
    chk(req, word_o, w, "directed word");
    chk(req, {15'd0, clip_o}, {15'd0, c}, "directed clip");
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (1000000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1", word_o, 16'h0000, "reset word");
    chk("R1", {14'd0, word_vld_o, clip_o}, 16'h0000, "reset flags");
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R3 one-sign pass-through
    drive(32767, 1, 1, 0, "R3");  expect_now("R3", 16'h7FFF, 0);
    drive(-32768, 1, 1, 0, "R3"); expect_now("R3", 16'h8000, 0);
    drive(1234, 1, 1, 0, "R3");   expect_now("R3", 16'h04D2, 0);
    // R4 one-sign clamp
    drive(32768, 1, 1, 0, "R4");   expect_now("R4", 16'h7FFF, 1);
    drive(-131072, 1, 1, 0, "R4"); expect_now("R4", 16'h8000, 1);
    drive(-32769, 1, 1, 1, "R9");  expect_now("R9", 16'h8000, 1);
    drive(0, 0, 1, 1, "R8");       expect_now("R8", 16'h8000, 0);
    // R5 two-sign pass-through
    drive(16383, 1, 0, 0, "R5");  expect_now("R5", 16'h3FFF, 0);
    drive(-16384, 1, 0, 0, "R5"); expect_now("R5", 16'hC000, 0);
    // R7 invalid out-of-range data ignored
    drive(131071, 0, 0, 0, "R7"); expect_now("R7", 16'hC000, 0);
    // R6 two-sign clamp
    drive(16384, 1, 0, 0, "R6");  expect_now("R6", 16'h3FFF, 1);
    drive(0, 0, 0, 0, "R8");      expect_now("R8", 16'h3FFF, 1);
    drive(-16385, 1, 0, 1, "R9"); expect_now("R9", 16'hC000, 1);
    drive(0, 0, 0, 1, "R8");      expect_now("R8", 16'hC000, 0);
    // R10 format switches per sample
    drive(20000, 1, 1, 0, "R10"); expect_now("R10", 16'h4E20, 0);
    drive(20000, 1, 0, 0, "R10"); expect_now("R10", 16'h3FFF, 1);
    drive(0, 0, 0, 1, "R8");
    // R2 mixed stimulus against the model
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 131071)) - 65536;
      if ($urandom_range(0, 1) == 0) r = r / 4;
      drive(r, $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
            $urandom_range(0, 5) == 0, "R2");
    end
    drive(0, 0, 0, 0, "R2");
    repeat (2) @(negedge clk_i);
    #1;
    finish_run();
  end
endmodule